// File: doc/BRIEF.md
# Key-Matrix Scan Encoder with Serial Code Frames

This block wakes up when a key of a drive-line by sense-line matrix closes. It scans the drive lines one at a time and turns the pressed key into a numeric key code. It then transmits a serial frame that carries a system code and a command code. The frame repeats for as long as the key stays down. A control bit in the frame flips after every release, so a receiver can tell a fresh press from an auto-repeat.

Two operating modes are selected by `ms_i`. In single-key mode a key on the X sense group sets the command code, and the system code already held is sent with it. In two-key mode the block needs one key on the Z group and one key on the X group. A first scan phase takes the system code from the Z key. A second phase takes the command code from the X key. Only then does the frame start.

Two test pins choose between normal operation, a held reset, a fast mode that skips debounce, and a quiet mode that suspends scanning.

Top module: `key_scan_encoder`

## Requirements
- R1: While the block is not scanning (idle, sending or waiting between frames), all drive lines are low. While scanning, exactly one drive line is low at a time. Drive lines are taken in ascending order, starting at drive 0, each for STEP_CYC cycles, and the order wraps from the last line to drive 0.
- R2: A key at drive line d and sense line s gets code d*N + s, where N is the size of the sense group being scanned (N_X or N_Z). When several keys read low in one pass, the lowest drive line wins, and within that line the lowest sense index wins.
- R3: With `ms_i` low, an X-group key loads its code into `cmd_o` and starts a frame. `sys_o` keeps whatever value it already held.
- R4: With `ms_i` high, the Z-group key code is loaded into `sys_o` during a first phase that reads only Z sense lines. The X-group key code is then loaded into `cmd_o` during a second phase that reads only X sense lines. No frame starts unless both a Z key and an X key are pressed.
- R5: A code is accepted only after DEB_N consecutive scan passes return the same key. A pass that finds no key abandons the press: no frame is sent, no latch changes, and the control bit is unchanged.
- R6: In two-key mode, if no Z-group connection is seen during a pass of the X phase, the press is abandoned with no frame and no change to `cmd_o`.
- R7: `ser_o` is 0 outside frames. A frame is FRM_W = 3 + 2*KEY_W bits, each bit lasting BIT_CYC cycles, sent in this order: 1, 1, control bit, `sys_o` LSB first, `cmd_o` LSB first. The latches stay stable while a frame is being sent.
- R8: While the key (or key pair) stays held, the same frame is sent again after GAP_CYC cycles of low `ser_o`, with the same control bit.
- R9: The control bit resets to 0. It inverts when the key is found released during the gap after a frame, and the block then returns to idle at once. An abandoned press does not change it.
- R10: `tt_i` = 2'b11 holds the block in reset: `sys_o`, `cmd_o` and the control bit become 0, `ser_o` becomes 0, and all drive lines go low.
- R11: `tt_i` = 2'b10 accepts a key after a single scan pass instead of DEB_N passes.
- R12: `tt_i` = 2'b01 suspends operation: all drive lines go low, `ser_o` is 0 and no frame starts. `sys_o`, `cmd_o` and the control bit are kept. `tt_i` = 2'b00 is normal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_ni | input | N_X | X-group sense lines, low when a key connects them to a low drive line |
| z_ni | input | N_Z | Z-group sense lines, low when a key connects them to a low drive line |
| ms_i | input | 1 | Mode select: 0 single-key, 1 two-key |
| tt_i | input | 2 | Test-mode select (00 normal, 11 reset, 10 fast debounce, 01 suspended) |
| drv_no | output | N_DRV | Scan drive lines, active low |
| sys_o | output | KEY_W | Latched system code |
| cmd_o | output | KEY_W | Latched command code |
| ser_o | output | 1 | Serial frame output |

## Verification
The drive-line checks assume that the sense lines are a pure function of the drive lines and the pressed keys. The bench meets this with a combinational matrix model that pulls a sense line low only through a pressed key whose drive line is low. The checks also assume that `ms_i` changes only while the block is idle and that `tt_i` changes only between presses. The bench sets mode and test pins only after it has released all keys and waited past the longest frame and gap. The latch-stability and test-mode properties rely on nothing beyond the pins themselves.

// File: rtl/kse_pkg.sv
package kse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCANZ,
    ST_SCANX,
    ST_TX,
    ST_GAP
  } kse_state_e;

  typedef enum logic [1:0] {
    TT_NORM = 2'b00,
    TT_QUIET = 2'b01,
    TT_FAST = 2'b10,
    TT_HOLD = 2'b11
  } kse_tt_e;
endpackage

// File: rtl/kse_scan.sv
module kse_scan #(
  parameter int N_DRV    = 4,
  parameter int N_X      = 4,
  parameter int N_Z      = 4,
  parameter int STEP_CYC = 4,
  parameter int KEY_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             sel_z_i,
  input  logic [N_X-1:0]   x_ni,
  input  logic [N_Z-1:0]   z_ni,
  output logic [N_DRV-1:0] drv_no,
  output logic             done_o,
  output logic             hit_o,
  output logic [KEY_W-1:0] code_o,
  output logic             zseen_o
);
  localparam int CYC_W = $clog2(STEP_CYC);
  localparam int DRV_W = $clog2(N_DRV);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(STEP_CYC - 1);
  localparam logic [DRV_W-1:0] DRV_LAST = DRV_W'(N_DRV - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [DRV_W-1:0] drv_q;
  logic             found_q, zacc_q;
  logic [KEY_W-1:0] code_q;
  logic             done_q, hit_q, zseen_q;
  logic [KEY_W-1:0] res_q;

  logic             samp, last, shit, z_low;
  int               sidx, ns;
  logic [KEY_W-1:0] step_code;

  always_comb begin
    samp  = en_i && (cyc_q == CYC_LAST);
    last  = samp && (drv_q == DRV_LAST);
    z_low = |(~z_ni);
    shit  = 1'b0;
    sidx  = 0;
    // lowest sense index wins within one drive step
    if (sel_z_i) begin
      for (int s = N_Z - 1; s >= 0; s--)
        if (!z_ni[s]) begin shit = 1'b1; sidx = s; end
    end else begin
      for (int s = N_X - 1; s >= 0; s--)
        if (!x_ni[s]) begin shit = 1'b1; sidx = s; end
    end
    ns        = sel_z_i ? N_Z : N_X;
    step_code = KEY_W'(int'(drv_q) * ns + sidx);
    drv_no    = en_i ? ~(N_DRV'(1) << drv_q) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0; drv_q <= '0; found_q <= 1'b0; zacc_q <= 1'b0; code_q <= '0;
      done_q <= 1'b0; hit_q <= 1'b0; zseen_q <= 1'b0; res_q <= '0;
    end else if (clr_i || !en_i) begin
      cyc_q <= '0; drv_q <= '0; found_q <= 1'b0; zacc_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (samp) begin
        cyc_q <= '0;
        drv_q <= last ? '0 : drv_q + 1'b1;
        if (last) begin
          found_q <= 1'b0;
          zacc_q  <= 1'b0;
          hit_q   <= found_q | shit;
          res_q   <= found_q ? code_q : step_code;
          zseen_q <= zacc_q | z_low;
        end else begin
          zacc_q <= zacc_q | z_low;
          if (!found_q && shit) begin
            found_q <= 1'b1;
            code_q  <= step_code;
          end
        end
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign done_o  = done_q;
  assign hit_o   = hit_q;
  assign code_o  = res_q;
  assign zseen_o = zseen_q;
endmodule

// File: rtl/kse_deb.sv
module kse_deb #(
  parameter int KEY_W = 4,
  parameter int DEB_N = 4,
  parameter int CNT_W = $clog2(DEB_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             done_i,
  input  logic             hit_i,
  input  logic [KEY_W-1:0] code_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             acc_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [KEY_W-1:0] cand_q;

  always_comb begin
    cnt_d = ((cnt_q != '0) && (code_i == cand_q)) ? cnt_q + 1'b1 : CNT_W'(1);
    acc_o = done_i && hit_i && (cnt_d >= need_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cand_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (done_i && hit_i) begin
      cnt_q  <= cnt_d;
      cand_q <= code_i;
    end
  end
endmodule

// File: rtl/kse_tx.sv
module kse_tx #(
  parameter int FRM_W   = 11,
  parameter int BIT_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic [FRM_W-1:0] frame_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ser_o
);
  localparam int BC_W  = $clog2(BIT_CYC);
  localparam int IDX_W = $clog2(FRM_W);
  localparam logic [BC_W-1:0]  BC_LAST  = BC_W'(BIT_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRM_W - 1);

  logic             busy_q;
  logic [BC_W-1:0]  cyc_q;
  logic [IDX_W-1:0] idx_q;
  logic [FRM_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; cyc_q <= '0; idx_q <= '0; sh_q <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0; cyc_q <= '0; idx_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1; cyc_q <= '0; idx_q <= '0; sh_q <= frame_i;
    end else if (busy_q) begin
      if (cyc_q == BC_LAST) begin
        cyc_q <= '0;
        sh_q  <= sh_q >> 1;
        if (idx_q == IDX_LAST) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cyc_q == BC_LAST) && (idx_q == IDX_LAST);
  assign ser_o  = busy_q & sh_q[0];
endmodule

// File: rtl/key_scan_encoder.sv
module key_scan_encoder
  import kse_pkg::*;
#(
  parameter int N_DRV    = 4,
  parameter int N_X      = 4,
  parameter int N_Z      = 4,
  parameter int STEP_CYC = 4,   // >= 2
  parameter int DEB_N    = 4,
  parameter int BIT_CYC  = 8,
  parameter int GAP_CYC  = 32,
  parameter int KEY_W    = $clog2(N_DRV * ((N_X > N_Z) ? N_X : N_Z))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_X-1:0]   x_ni,
  input  logic [N_Z-1:0]   z_ni,
  input  logic             ms_i,
  input  logic [1:0]       tt_i,
  output logic [N_DRV-1:0] drv_no,
  output logic [KEY_W-1:0] sys_o,
  output logic [KEY_W-1:0] cmd_o,
  output logic             ser_o
);
  localparam int FRM_W = 3 + 2 * KEY_W;
  localparam int CNT_W = $clog2(DEB_N + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

  kse_state_e       st_q, st_d;
  logic [KEY_W-1:0] sys_q, cmd_q;
  logic             ctrl_q, two_q;
  logic [GAP_W-1:0] gap_q;

  logic hold, quiet, fast, x_any, z_any, held;
  logic tx_start, sys_ld, cmd_ld, deb_clr, flip;
  logic scan_en, scan_done, scan_hit, scan_zseen, deb_acc;
  logic [KEY_W-1:0] scan_code;
  logic [CNT_W-1:0] need;
  logic [FRM_W-1:0] frame;
  logic tx_busy, tx_done;

  assign hold    = (tt_i == TT_HOLD);
  assign quiet   = (tt_i == TT_QUIET);
  assign fast    = (tt_i == TT_FAST);
  assign need    = fast ? CNT_W'(1) : CNT_W'(DEB_N);
  assign x_any   = |(~x_ni);
  assign z_any   = |(~z_ni);
  assign held    = two_q ? (x_any & z_any) : x_any;
  assign scan_en = (st_q == ST_SCANZ) || (st_q == ST_SCANX);
  assign frame   = {cmd_ld ? scan_code : cmd_q, sys_q, ctrl_q, 2'b11};

  kse_scan #(.N_DRV(N_DRV), .N_X(N_X), .N_Z(N_Z), .STEP_CYC(STEP_CYC), .KEY_W(KEY_W)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(hold), .en_i(scan_en),
    .sel_z_i(st_q == ST_SCANZ), .x_ni(x_ni), .z_ni(z_ni), .drv_no(drv_no),
    .done_o(scan_done), .hit_o(scan_hit), .code_o(scan_code), .zseen_o(scan_zseen)
  );

  kse_deb #(.KEY_W(KEY_W), .DEB_N(DEB_N), .CNT_W(CNT_W)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(deb_clr | hold), .done_i(scan_done),
    .hit_i(scan_hit), .code_i(scan_code), .need_i(need), .acc_o(deb_acc)
  );

  kse_tx #(.FRM_W(FRM_W), .BIT_CYC(BIT_CYC)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(hold | quiet), .start_i(tx_start),
    .frame_i(frame), .busy_o(tx_busy), .done_o(tx_done), .ser_o(ser_o)
  );

  always_comb begin
    st_d = st_q; tx_start = 1'b0; sys_ld = 1'b0; cmd_ld = 1'b0;
    deb_clr = 1'b0; flip = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        deb_clr = 1'b1;
        if (ms_i ? (x_any & z_any) : x_any) st_d = ms_i ? ST_SCANZ : ST_SCANX;
      end
      ST_SCANZ: begin
        if (scan_done && !scan_hit) begin
          st_d = ST_IDLE; deb_clr = 1'b1;
        end else if (deb_acc) begin
          sys_ld = 1'b1; deb_clr = 1'b1; st_d = ST_SCANX;
        end
      end
      ST_SCANX: begin
        if (scan_done && (!scan_hit || (two_q && !scan_zseen))) begin
          st_d = ST_IDLE; deb_clr = 1'b1;
        end else if (deb_acc) begin
          cmd_ld = 1'b1; tx_start = 1'b1; deb_clr = 1'b1; st_d = ST_TX;
        end
      end
      ST_TX: if (tx_done) st_d = ST_GAP;
      ST_GAP: begin
        if (!held) begin
          flip = 1'b1; st_d = ST_IDLE;
        end else if (gap_q == GAP_LAST) begin
          tx_start = 1'b1; st_d = ST_TX;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (quiet) begin
      st_d = ST_IDLE; tx_start = 1'b0; sys_ld = 1'b0; cmd_ld = 1'b0; flip = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sys_q <= '0; cmd_q <= '0; ctrl_q <= 1'b0; two_q <= 1'b0; gap_q <= '0;
    end else if (hold) begin
      st_q <= ST_IDLE; sys_q <= '0; cmd_q <= '0; ctrl_q <= 1'b0; two_q <= 1'b0; gap_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) two_q <= ms_i;
      if (sys_ld) sys_q <= scan_code;
      if (cmd_ld) cmd_q <= scan_code;
      if (flip)   ctrl_q <= ~ctrl_q;
      gap_q <= (st_q == ST_GAP) ? gap_q + 1'b1 : '0;
    end
  end

  assign sys_o = sys_q;
  assign cmd_o = cmd_q;
endmodule

// File: rtl/kse_chk.sv
module kse_chk #(
  parameter int N_DRV = 4,
  parameter int KEY_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       tt_i,
  input logic [N_DRV-1:0] drv_no,
  input logic             ser_o,
  input logic [KEY_W-1:0] sys_o,
  input logic [KEY_W-1:0] cmd_o,
  input logic             tx_busy_i
);
  logic [N_DRV-1:0] act;
  logic             one_now, all_now;
  assign act     = ~drv_no;
  assign one_now = ($countones(act) == 1);
  assign all_now = (act == '1);

  p_drive_shape_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_now || all_now));

  p_drive_ascend_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_now && $past(one_now) && (act != $past(act)))
      |-> ((act == ($past(act) << 1)) || (act == N_DRV'(1))));

  p_drive_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(all_now) && one_now) |-> (act == N_DRV'(1)));

  p_latch_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_i && $past(tx_busy_i)) |-> ($stable(sys_o) && $stable(cmd_o)));

  p_hold_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tt_i == 2'b11) |=> ((sys_o == '0) && (cmd_o == '0) && !ser_o && (drv_no == '0)));

  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tt_i == 2'b01) |=> ((drv_no == '0) && !ser_o));
endmodule

bind key_scan_encoder kse_chk #(.N_DRV(N_DRV), .KEY_W(KEY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tt_i(tt_i), .drv_no(drv_no), .ser_o(ser_o),
  .sys_o(sys_o), .cmd_o(cmd_o), .tx_busy_i(tx_busy)
);

// File: tb/key_scan_encoder_test.sv
`timescale 1ns/1ps
module key_scan_encoder_test;
  localparam int NDRV = 4, NX = 4, NZ = 4, STEP = 2, DEB = 4, BITC = 4, GAP = 6;
  localparam int KW = 4, FRM = 3 + 2 * KW, PASS = NDRV * STEP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NX-1:0] x_n;
  logic [NZ-1:0] z_n;
  logic ms = 1'b0;
  logic [1:0] tt = 2'b00;
  logic [NDRV-1:0] drv_n;
  logic [KW-1:0] sys, cmd;
  logic ser;
  logic [NDRV*NX-1:0] kx = '0;
  logic [NDRV*NZ-1:0] kz = '0;

  int total = 0, fails = 0, rises = 0, viol = 0, steps = 0;
  bit fin = 1'b0, exp_ctrl = 1'b0, mon_on = 1'b0;
  int exp_sys = 0;

  always #2.5 clk = ~clk;

  key_scan_encoder #(.N_DRV(NDRV), .N_X(NX), .N_Z(NZ), .STEP_CYC(STEP), .DEB_N(DEB),
    .BIT_CYC(BITC), .GAP_CYC(GAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .x_ni(x_n), .z_ni(z_n), .ms_i(ms), .tt_i(tt),
    .drv_no(drv_n), .sys_o(sys), .cmd_o(cmd), .ser_o(ser));

  // key matrix model
  always_comb begin
    x_n = '1; z_n = '1;
    for (int d = 0; d < NDRV; d++) begin
      for (int s = 0; s < NX; s++) if (!drv_n[d] && kx[d*NX+s]) x_n[s] = 1'b0;
      for (int s = 0; s < NZ; s++) if (!drv_n[d] && kz[d*NZ+s]) z_n[s] = 1'b0;
    end
  end

  // drive-line monitor and frame-start counter
  logic [NDRV-1:0] pact = '1;
  logic pser = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      logic [NDRV-1:0] a;
      a = ~drv_n;
      if (!($countones(a) == 1 || a == '1)) viol++;
      if ($countones(a) == 1) begin
        steps++;
        if (pact == '1 && a != 1) viol++;
        if ($countones(pact) == 1 && a != pact && a != (pact << 1) && a != 1) viol++;
      end
      if (ser && !pser) rises++;
      pact = a;
      pser = ser;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_frame(output bit got, output logic [FRM-1:0] b);
    int n = 0;
    got = 1'b0; b = '0;
    while (ser !== 1'b0 && n < 400) begin @(negedge clk); n++; end
    while (ser !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) return;
    got = 1'b1;
    @(negedge clk); b[0] = ser;
    for (int i = 1; i < FRM; i++) begin
      repeat (BITC) @(negedge clk);
      b[i] = ser;
    end
  endtask

  task automatic run_frame(input string req, input int esys, input int ecmd);
    bit got;
    logic [FRM-1:0] b;
    get_frame(got, b);
    chk(got, {req, " frame seen"}, got, 1);
    chk(b[1:0] == 2'b11, "R7 start bits", b[1:0], 3);
    chk(b[2] == exp_ctrl, "R9 control bit", b[2], exp_ctrl);
    chk(b[3 +: KW] == esys, {req, " frame system code"}, b[3 +: KW], esys);
    chk(b[3+KW +: KW] == ecmd, {req, " frame command code"}, b[3+KW +: KW], ecmd);
    chk(cmd == ecmd, {req, " cmd_o"}, cmd, ecmd);
    chk(sys == esys, {req, " sys_o"}, sys, esys);
  endtask

  task automatic release_all(input bit sent);
    kx = '0; kz = '0;
    repeat (70) @(negedge clk);
    if (sent) exp_ctrl = ~exp_ctrl;
    chk(ser == 1'b0, "R7 ser idle after release", ser, 0);
  endtask

  task automatic press1(input int k);
    kx = '0; kx[k] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int r0, n, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    // R10 reset state
    chk(drv_n == '0, "R10 reset drive lines low", drv_n, 0);
    chk(ser == 1'b0 && sys == 0 && cmd == 0, "R10 reset outputs zero", {ser, sys, cmd}, 0);

    // R3 / R2: sweep every X key in single-key mode
    for (int k = 0; k < NDRV*NX; k++) begin
      press1(k);
      run_frame("R3", exp_sys, k);
      release_all(1'b1);
    end

    // R2 priority: lowest drive, then lowest sense
    kx = '0; kx[2*NX+3] = 1; kx[1*NX+2] = 1; kx[1*NX+0] = 1;
    run_frame("R2 priority a", exp_sys, 4);
    release_all(1'b1);
    kx = '0; kx[3*NX+2] = 1; kx[3*NX+0] = 1;
    run_frame("R2 priority b", exp_sys, 12);
    release_all(1'b1);

    // R8 repeat while held
    press1(9);
    run_frame("R8 first", exp_sys, 9);
    run_frame("R8 repeat", exp_sys, 9);
    release_all(1'b1);

    // R5 short press abandoned
    r0 = rises; c0 = cmd;
    press1(5);
    repeat (PASS + 4) @(negedge clk);
    kx = '0;
    repeat (100) @(negedge clk);
    chk(rises == r0, "R5 no frame on short press", rises - r0, 0);
    chk(cmd == c0, "R5 cmd unchanged on short press", cmd, c0);

    // R4: two-key sweep over all Z keys
    ms = 1'b1;
    for (int i = 0; i < NDRV*NZ; i++) begin
      int j;
      j = (i * 5 + 3) % (NDRV*NX);
      kz = '0; kz[i] = 1'b1; kx = '0; kx[j] = 1'b1;
      run_frame("R4", i, j);
      exp_sys = i;
      release_all(1'b1);
    end

    // R4: Z key alone sends nothing
    r0 = rises;
    kz = '0; kz[6] = 1'b1;
    repeat (120) @(negedge clk);
    chk(rises == r0, "R4 no frame with Z key only", rises - r0, 0);
    chk(sys == exp_sys, "R4 sys unchanged with Z key only", sys, exp_sys);
    kz = '0;
    repeat (20) @(negedge clk);

    // R6: Z released during X phase
    r0 = rises; c0 = cmd;
    kz = '0; kz[1] = 1'b1; kx = '0; kx[15] = 1'b1;
    n = 0;
    while (sys != 1 && n < 300) begin @(negedge clk); n++; end
    chk(sys == 1, "R6 system code loaded first", sys, 1);
    exp_sys = 1;
    kz = '0;
    repeat (120) @(negedge clk);
    chk(rises == r0, "R6 no frame after Z release", rises - r0, 0);
    chk(cmd == c0, "R6 cmd unchanged after Z release", cmd, c0);
    kx = '0;
    repeat (20) @(negedge clk);
    ms = 1'b0;
    repeat (4) @(negedge clk);

    // R3: single-key mode keeps system code from two-key press
    press1(10);
    run_frame("R3 keeps sys", exp_sys, 10);
    release_all(1'b1);

    // R5 / R11 latency: normal vs fast debounce
    press1(9);
    n = 0;
    while (ser !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    chk(n >= DEB*PASS, "R5 debounce latency", n, DEB*PASS);
    release_all(1'b1);
    tt = 2'b10;
    @(negedge clk);
    press1(2);
    n = 0;
    while (ser !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    chk(n < 2*PASS, "R11 fast-mode latency", n, PASS);
    release_all(1'b1);
    chk(cmd == 2, "R11 fast-mode code", cmd, 2);
    tt = 2'b00;
    @(negedge clk);

    // R12 quiet mode
    r0 = rises; c0 = cmd;
    tt = 2'b01;
    @(negedge clk);
    press1(7);
    repeat (100) @(negedge clk);
    chk(rises == r0, "R12 no frame in quiet mode", rises - r0, 0);
    chk(drv_n == '0, "R12 drive lines low in quiet mode", drv_n, 0);
    chk(cmd == c0, "R12 cmd kept in quiet mode", cmd, c0);
    tt = 2'b00;
    run_frame("R12 resume", exp_sys, 7);
    release_all(1'b1);

    // R10 held reset clears latches and control bit
    if (!exp_ctrl) begin
      press1(3);
      run_frame("R9 extra", exp_sys, 3);
      release_all(1'b1);
    end
    chk(exp_ctrl == 1'b1, "R9 control bit set before hold", exp_ctrl, 1);
    tt = 2'b11;
    repeat (3) @(negedge clk);
    chk(sys == 0 && cmd == 0, "R10 hold clears codes", {sys, cmd}, 0);
    chk(ser == 0 && drv_n == '0, "R10 hold quiets pins", {ser, drv_n}, 0);
    tt = 2'b00;
    exp_ctrl = 1'b0; exp_sys = 0;
    @(negedge clk);
    press1(13);
    run_frame("R10 after hold", 0, 13);
    release_all(1'b1);

    chk(viol == 0, "R1 drive order", viol, 0);
    chk(steps > 0, "R1 scanning observed", steps, 1);

    fin = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule